// File: doc/BRIEF.md
# Data-Enable Driven Panel Timing Generator

This block turns a pixel clock and a single data-enable strobe into the control strobes that the row and column drivers of a TFT panel expect. It needs no horizontal or vertical sync inputs. The line boundaries come from the edges of DE. A frame boundary is a DE-low gap longer than a programmable threshold. The block counts the active pixels in each line and classifies the line as narrow (1024 pixels by default) or wide (1280 pixels by default). It switches its pulse placement to that class without any external mode select.

Two position counters are kept. One counts clocks since DE last fell, and the line latch pulse, the gate clock and the polarity flip are placed on it. The other counts clocks since DE last rose, and it measures line width and delays the gate start pulse. In wide mode, a fixed extra delay is added to the latch pulse and the gate clock. The configuration inputs and the detected mode are captured only when a frame begins, so a frame is never split between two sets of settings. One clock carries one pixel on a single-port feed, or a pixel pair at half rate on a dual-port feed. The counts here are in clocks.

Top module: `de_panel_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is 0.
- R2: `src_start` is high for exactly one cycle: the cycle after the clock edge that first samples DE high after a low sample.
- R3: Let k be the number of clocks since DE was first sampled low, with k=0 in the cycle after that edge. `line_latch` is high exactly when S <= k < S+W. S is the latched LP start, plus WIDE_SHIFT when the latched mode is wide. W is the latched LP width, and W=0 gives no pulse.
- R4: `gate_clk` follows the R3 rule with its own latched start and width, and with the same WIDE_SHIFT.
- R5: A DE rise is a frame start when DE was low for more than `cfg_blank_min` consecutive clock samples before it. The first DE rise after reset is always a frame start.
- R6: Let m be the number of clock samples since the frame-start rise, counting the rise edge itself and saturating at 2^ceil(log2(2*WIDE_PIX))-1. In the cycle for count m, `gate_start` is high exactly when m > the latched gate delay. It drops at the next DE rise.
- R7: `pol` toggles once per line and becomes visible at k=S+1, with S and k as in R3. At each frame start it is loaded with a phase that alternates from frame to frame. That phase is 1 for the first frame after reset.
- R8: A line counts as wide when its DE-high length is at least (NARROW_PIX+WIDE_PIX)/2 clocks. `wide_mode` takes the new class at the DE falling edge only when that line and the previous line have the same class. It changes at no other time and is 0 after reset.
- R9: All `cfg_*` inputs except `cfg_blank_min`, and the current `wide_mode`, are captured only at a frame start. Changes made in the middle of a frame do not affect the pulses of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de | input | 1 | Data-enable strobe |
| cfg_lp_start | input | CFG_W | Line latch start, in clocks after DE falls |
| cfg_lp_width | input | CFG_W | Line latch width in clocks |
| cfg_gclk_start | input | CFG_W | Gate clock start, in clocks after DE falls |
| cfg_gclk_width | input | CFG_W | Gate clock width in clocks |
| cfg_gate_delay | input | CFG_W | Gate start delay after the frame-start rise |
| cfg_blank_min | input | CFG_W | DE-low length that must be exceeded to start a frame |
| line_latch | output | 1 | Line latch pulse |
| pol | output | 1 | Polarity |
| gate_clk | output | 1 | Gate (row) clock |
| gate_start | output | 1 | Gate start pulse, one line long |
| src_start | output | 1 | Source start pulse at each line start |
| wide_mode | output | 1 | Detected wide (1280) line mode |

## Verification
The assertions check four things on every cycle. The source start pulse is never longer than one clock. The mode flag moves only in the cycle after a DE falling edge. The gate start pulse ends only together with a new line start. The gate line flag rises only after a DE rise. Exact pulse placement cannot be shown by a per-cycle property, so the bench scenarios cover it. This includes the wide-mode shift of the latch and gate clock windows, the polarity phase alternating across frames, the two-line agreement that filters mode glitches, the exact blanking threshold for a frame start, and the fact that settings changed mid-frame are ignored.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    parameter int CFG_W  = 8;
    localparam int HPOS_W = CFG_W + 2;

    typedef logic [CFG_W-1:0]  cfg_val_t;
    typedef logic [HPOS_W-1:0] hpos_t;

    typedef struct packed {
        cfg_val_t lp_start;
        cfg_val_t lp_width;
        cfg_val_t ck_start;
        cfg_val_t ck_width;
        cfg_val_t gs_delay;
    } ptg_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } de_evt_t;

    localparam ptg_cfg_t CFG_RESET = '0;

    // True when pos lies in [start, start+len)
    function automatic logic in_window(hpos_t pos, hpos_t start, cfg_val_t len);
        logic [HPOS_W:0] stop;
        stop = {1'b0, start} + {{(HPOS_W+1-CFG_W){1'b0}}, len};
        return ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < stop);
    endfunction

endpackage

// File: rtl/ptg_de_track.sv
module ptg_de_track import ptg_pkg::*; #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de,
    output de_evt_t          evt,
    output hpos_t            hpos,
    output logic [PIX_W-1:0] lpos,
    output logic             src_start
);

    logic de_d;

    assign evt.rise = de & ~de_d;
    assign evt.fall = ~de & de_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_d      <= 1'b0;
            hpos      <= '1;
            lpos      <= '0;
            src_start <= 1'b0;
        end else begin
            de_d      <= de;
            src_start <= evt.rise;
            // clocks since DE went low, saturating
            if (evt.fall)
                hpos <= '0;
            else if (hpos != '1)
                hpos <= hpos + 1'b1;
            // clocks since DE went high, saturating; equals line width at fall
            if (evt.rise)
                lpos <= PIX_W'(1);
            else if (lpos != '1)
                lpos <= lpos + 1'b1;
        end
    end

    // R2: a rise cannot follow a rise in the next cycle
    a_r2_src_start_single: assert property (@(posedge clk) disable iff (rst)
        src_start |=> !src_start);

endmodule

// File: rtl/ptg_mode_detect.sv
module ptg_mode_detect #(
    parameter int PIX_W     = 12,
    parameter int SPLIT_PIX = 1152
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic [PIX_W-1:0] line_len,
    output logic             wide
);

    logic prev_cls;
    logic cur_cls;

    assign cur_cls = (line_len >= PIX_W'(SPLIT_PIX));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cls <= 1'b0;
            wide     <= 1'b0;
        end else if (line_end) begin
            prev_cls <= cur_cls;
            if (cur_cls == prev_cls)
                wide <= cur_cls;
        end
    end

endmodule

// File: rtl/ptg_frame_ctrl.sv
module ptg_frame_ctrl import ptg_pkg::*; #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  hpos_t            hpos,
    input  logic [PIX_W-1:0] lpos,
    input  ptg_cfg_t         cfg_req,
    input  cfg_val_t         blank_min,
    input  logic             wide,
    input  hpos_t            lp_start_eff,
    output ptg_cfg_t         cfg_act,
    output logic             act_wide,
    output logic             gate_start,
    output logic             pol
);

    logic frame_start;
    logic frame_phase;
    logic gline;

    assign frame_start = rise && (hpos >= {2'b00, blank_min});

    assign gate_start = gline &&
        ({{CFG_W{1'b0}}, lpos} > {{PIX_W{1'b0}}, cfg_act.gs_delay});

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act     <= CFG_RESET;
            act_wide    <= 1'b0;
            frame_phase <= 1'b0;
            pol         <= 1'b0;
            gline       <= 1'b0;
        end else begin
            if (frame_start) begin
                cfg_act     <= cfg_req;
                act_wide    <= wide;
                frame_phase <= ~frame_phase;
                pol         <= ~frame_phase;
            end else if (hpos == lp_start_eff) begin
                pol <= ~pol;
            end
            if (rise)
                gline <= frame_start;
        end
    end

    // R5: the first-line flag can only be raised by a DE rise
    a_r5_gline_from_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(gline) |-> $past(rise));

endmodule

// File: rtl/ptg_pulse_win.sv
module ptg_pulse_win import ptg_pkg::*; (
    input  hpos_t    pos,
    input  hpos_t    start,
    input  cfg_val_t len,
    output logic     hit
);

    assign hit = in_window(pos, start, len);

endmodule

// File: rtl/de_panel_timer.sv
module de_panel_timer import ptg_pkg::*; #(
    parameter int NARROW_PIX = 1024,
    parameter int WIDE_PIX   = 1280,
    parameter int WIDE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de,
    input  logic [CFG_W-1:0] cfg_lp_start,
    input  logic [CFG_W-1:0] cfg_lp_width,
    input  logic [CFG_W-1:0] cfg_gclk_start,
    input  logic [CFG_W-1:0] cfg_gclk_width,
    input  logic [CFG_W-1:0] cfg_gate_delay,
    input  logic [CFG_W-1:0] cfg_blank_min,
    output logic             line_latch,
    output logic             pol,
    output logic             gate_clk,
    output logic             gate_start,
    output logic             src_start,
    output logic             wide_mode
);

    localparam int SPLIT_PIX = (NARROW_PIX + WIDE_PIX) / 2;
    localparam int PIX_W     = $clog2(WIDE_PIX * 2);
    localparam int N_WIN     = 2;

    de_evt_t          evt;
    hpos_t            hpos;
    logic [PIX_W-1:0] lpos;
    ptg_cfg_t         cfg_req;
    ptg_cfg_t         cfg_act;
    logic             act_wide;
    hpos_t            shift_amt;
    hpos_t            win_start [N_WIN];
    cfg_val_t         win_len   [N_WIN];
    logic [N_WIN-1:0] win_hit;

    assign cfg_req.lp_start = cfg_lp_start;
    assign cfg_req.lp_width = cfg_lp_width;
    assign cfg_req.ck_start = cfg_gclk_start;
    assign cfg_req.ck_width = cfg_gclk_width;
    assign cfg_req.gs_delay = cfg_gate_delay;

    ptg_de_track #(.PIX_W(PIX_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .de        (de),
        .evt       (evt),
        .hpos      (hpos),
        .lpos      (lpos),
        .src_start (src_start)
    );

    ptg_mode_detect #(.PIX_W(PIX_W), .SPLIT_PIX(SPLIT_PIX)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .line_end (evt.fall),
        .line_len (lpos),
        .wide     (wide_mode)
    );

    // wide lines need later latch and gate clock placement
    assign shift_amt    = act_wide ? HPOS_W'(WIDE_SHIFT) : '0;
    assign win_start[0] = HPOS_W'(cfg_act.lp_start) + shift_amt;
    assign win_len[0]   = cfg_act.lp_width;
    assign win_start[1] = HPOS_W'(cfg_act.ck_start) + shift_amt;
    assign win_len[1]   = cfg_act.ck_width;

    ptg_frame_ctrl #(.PIX_W(PIX_W)) u_frame (
        .clk          (clk),
        .rst          (rst),
        .rise         (evt.rise),
        .hpos         (hpos),
        .lpos         (lpos),
        .cfg_req      (cfg_req),
        .blank_min    (cfg_blank_min),
        .wide         (wide_mode),
        .lp_start_eff (win_start[0]),
        .cfg_act      (cfg_act),
        .act_wide     (act_wide),
        .gate_start   (gate_start),
        .pol          (pol)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        ptg_pulse_win u_win (
            .pos   (hpos),
            .start (win_start[g]),
            .len   (win_len[g]),
            .hit   (win_hit[g])
        );
    end

    assign line_latch = win_hit[0];
    assign gate_clk   = win_hit[1];

    // R8: the mode flag moves only right after a DE falling edge
    a_r8_mode_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(wide_mode) |-> $past(evt.fall));

    // R6: gate start ends only together with a new line start
    a_r6_gate_start_ends_on_line: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_start) |-> src_start);

endmodule

// File: tb/de_panel_timer_tb.sv
module de_panel_timer_tb;

    localparam int NPIX    = 16;
    localparam int WPIX    = 20;
    localparam int SHIFT   = 4;
    localparam int SPLIT   = (NPIX + WPIX) / 2;
    localparam int PIX_MAX = (1 << $clog2(2 * WPIX)) - 1;
    localparam int VTHR    = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       de  = 1'b0;
    logic [7:0] c_ls = '0, c_lw = '0, c_cs = '0, c_cw = '0, c_tg = '0;
    logic [7:0] c_vb = 8'(VTHR);
    logic       lp, pol, gclk, gst, sst, wide;

    // 250 MHz: 4 ns period
    always #2 clk = ~clk;

    de_panel_timer #(.NARROW_PIX(NPIX), .WIDE_PIX(WPIX), .WIDE_SHIFT(SHIFT)) u_dut (
        .clk(clk), .rst(rst), .de(de),
        .cfg_lp_start(c_ls), .cfg_lp_width(c_lw),
        .cfg_gclk_start(c_cs), .cfg_gclk_width(c_cw),
        .cfg_gate_delay(c_tg), .cfg_blank_min(c_vb),
        .line_latch(lp), .pol(pol), .gate_clk(gclk),
        .gate_start(gst), .src_start(sst), .wide_mode(wide)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    int a_ls = 0, a_lw = 0, a_cs = 0, a_cw = 0, a_tg = 0;
    bit a_wide = 0, e_fph = 0, e_pol = 0, e_wide = 0, e_prev = 0, e_gline = 0;
    int last_nb = 100000;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(int v);
        return (v > PIX_MAX) ? PIX_MAX : v;
    endfunction

    task automatic run_line(int npix, int nb);
        bit fs;
        bit cls;
        int ls, cs;
        fs = last_nb > int'(c_vb);          // R5
        de = 1'b1;
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            if (i == 0) begin
                if (fs) begin               // R9 capture
                    a_ls = c_ls; a_lw = c_lw; a_cs = c_cs; a_cw = c_cw; a_tg = c_tg;
                    a_wide = e_wide;
                    e_fph = !e_fph;
                    e_pol = e_fph;
                end
                e_gline = fs;
            end
            chk("R2 src_start", int'(sst), int'(i == 0));
            chk("R6 gate_start", int'(gst), int'(e_gline && (sat(i + 1) > a_tg)));
            chk("R3 line_latch in data", int'(lp), 0);
            chk("R4 gate_clk in data", int'(gclk), 0);
            chk("R7 pol", int'(pol), int'(e_pol));
            chk("R8 wide_mode", int'(wide), int'(e_wide));
        end
        de = 1'b0;
        cls = (npix >= SPLIT);
        if (cls == e_prev) e_wide = cls;
        e_prev = cls;
        ls = a_ls + (a_wide ? SHIFT : 0);
        cs = a_cs + (a_wide ? SHIFT : 0);
        for (int j = 0; j < nb; j++) begin
            @(negedge clk);
            if (j == ls + 1) e_pol = !e_pol;
            chk("R3/R9 line_latch", int'(lp), int'(j >= ls && j < ls + a_lw));
            chk("R4/R9 gate_clk", int'(gclk), int'(j >= cs && j < cs + a_cw));
            chk("R7 pol", int'(pol), int'(e_pol));
            chk("R8 wide_mode", int'(wide), int'(e_wide));
            chk("R2 src_start idle", int'(sst), 0);
            chk("R6 gate_start", int'(gst), int'(e_gline && (sat(npix + 1 + j) > a_tg)));
        end
        last_nb = nb;
    endtask

    function automatic int pick(int it, int k);
        return (((it * 7 + 3) >> k) & 1) ? WPIX : NPIX;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 line_latch reset", int'(lp), 0);
        chk("R1 pol reset", int'(pol), 0);
        chk("R1 gate_clk reset", int'(gclk), 0);
        chk("R1 gate_start reset", int'(gst), 0);
        chk("R1 src_start reset", int'(sst), 0);
        chk("R1 wide_mode reset", int'(wide), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pol after reset", int'(pol), 0);
        chk("R1 line_latch after reset", int'(lp), 0);

        // sweep of latch start/width; gate clock and delay derived from them
        for (int ls = 0; ls < 6; ls++) begin
            for (int lw = 0; lw < 4; lw++) begin
                int it;
                it = ls * 4 + lw;
                c_ls = 8'(ls); c_lw = 8'(lw);
                c_cs = 8'((ls + 2) % 6); c_cw = 8'((lw + 1) % 4);
                c_tg = 8'(lw);
                run_line(pick(it, 0), 15);
                // mid-frame disturbance: R9 says it must not take effect
                c_ls = 8'(ls + 3); c_lw = 8'((lw + 1) % 4);
                c_cs = 8'(ls); c_cw = 8'(3 - lw); c_tg = 8'(3 - lw);
                run_line(pick(it, 1), 20);      // blank equal to threshold: no frame (R5)
                run_line(pick(it, 2), 15);
                run_line(pick(it, 3), 21);      // blank one above threshold: frame (R5)
            end
        end

        // R8 glitch filter: isolated wide or narrow lines do not switch mode
        c_ls = 8'd1; c_lw = 8'd2; c_cs = 8'd3; c_cw = 8'd1; c_tg = 8'd0;
        run_line(NPIX, 15);
        run_line(WPIX, 15);
        run_line(NPIX, 15);
        run_line(WPIX, 15);
        run_line(WPIX, 15);
        run_line(NPIX, 15);
        run_line(WPIX, 21);
        run_line(WPIX, 15);                     // frame captured in wide mode (R9)
        run_line(NPIX, 15);
        run_line(NPIX, 21);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (R1-related run stall): got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule